// File: doc/BRIEF.md
# Supply-Monitor Reset Sequencer

This block produces the system reset for a processor supervisor. It takes three inputs. The first is a power-up indication that resets the block asynchronously while power is not yet applied. The second is a supply-low flag from an external comparator; the block synchronizes it. The third is a single-cycle timeout pulse from a separate watchdog counter. From these it drives one reset output, whose active level is chosen by a parameter. Reset is held from the moment power is applied. It asserts whenever the supply is low. It is released only after the supply has stayed good for a hold time, counted in clock cycles.

A small state machine holds the sequence. It has three states. `ST_SUPPLY_LOW` covers power-up and low-supply periods. `ST_HOLD` is the release window, in which the hold timer counts. `ST_RUN` is the state with reset released. The transitions are:

- `T_GOOD`: from `ST_SUPPLY_LOW` to `ST_HOLD` when the synchronized flag clears.
- `T_DIP`: from `ST_HOLD` or `ST_RUN` to `ST_SUPPLY_LOW` when the flag is seen high.
- `T_EXPIRE`: from `ST_HOLD` to `ST_RUN` when the hold timer ends.
- `T_WDOG`: from `ST_RUN` to `ST_HOLD` on a watchdog pulse.
- `T_REHOLD`: from `ST_HOLD` back to `ST_HOLD` with the timer cleared, on a watchdog pulse.

A supply-triggered reset and a watchdog-triggered reset therefore share one hold duration.

Top module: `supply_reset_seq`

## Requirements
- R1: While `pwr_up_n` is low, `rst_out` is at its asserted level. This holds at once, without waiting for a clock edge.
- R2: When `supply_low` is first sampled high at rising edge n, `rst_out` is asserted after edge n+2. It stays asserted for as long as the flag remains high.
- R3: Let edge m be the first rising edge that samples `supply_low` low after a low period or after power-up. `rst_out` is released exactly after edge m+HOLD_CYCLES+2 and not earlier. The first edge after `pwr_up_n` rises counts as such an edge.
- R4: A supply dip seen during the hold window restarts the hold. Release then follows R3, with m taken from the end of the dip, including a one-cycle glitch at the last cycle of the window.
- R5: While released, a `wdt_timeout` pulse sampled at edge w asserts `rst_out` after edge w. Reset is released after edge w+HOLD_CYCLES.
- R6: A `wdt_timeout` pulse sampled at edge w during the hold window restarts it. Release follows after edge w+HOLD_CYCLES.
- R7: A `wdt_timeout` pulse while the supply is low has no effect on release timing, which stays as given by R3.
- R8: The asserted level of `rst_out` is 0 when `ACTIVE_LOW` is 1 and 1 when `ACTIVE_LOW` is 0. The released level is the opposite.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| pwr_up_n | input | 1 | Power-up indication, low while power is not applied (asynchronous block reset) |
| supply_low | input | 1 | Comparator flag, high when the supply is below the trip point (asynchronous to clk) |
| wdt_timeout | input | 1 | Single-cycle watchdog timeout pulse, synchronous to clk |
| rst_out | output | 1 | System reset, active level set by `ACTIVE_LOW` |

## Verification
The assertions assume that `wdt_timeout` is a clean synchronous pulse. They also assume that the supply flag reaches the state machine only through the two-flop synchronizer, so each property is written against the synchronized flag. Each property is also written against the timer's end-of-hold signal, never against raw pad timing. The stimulus changes every input only on falling clock edges. This keeps the flag stable at each sampling edge and makes exact release edges predictable. Dips, glitches and watchdog pulses are placed at edge numbers counted from the start of each vector, and each one is chosen to fall inside the state it is meant to test.

// File: rtl/srs_pkg.sv
`timescale 1ns/1ps
package srs_pkg;

    typedef enum logic [1:0] {
        ST_SUPPLY_LOW = 2'd0,
        ST_HOLD       = 2'd1,
        ST_RUN        = 2'd2
    } seq_state_t;

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/srs_sync.sv
`timescale 1ns/1ps
module srs_sync #(
    parameter int unsigned STAGES    = 2,
    parameter bit          RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic arst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) chain[i] <= RESET_VAL;
                else         chain[i] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) chain[i] <= RESET_VAL;
                else         chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/srs_hold_timer.sv
`timescale 1ns/1ps
module srs_hold_timer
    import srs_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES = 10_000_000
) (
    input  logic clk,
    input  logic arst_n,
    input  logic clr,
    input  logic en,
    output logic done
);
    localparam int unsigned CW     = cnt_width(HOLD_CYCLES);
    localparam int unsigned LAST_I = HOLD_CYCLES - 1;
    localparam logic [CW-1:0] LAST = LAST_I[CW-1:0];

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (en && (cnt != LAST)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = en && !clr && (cnt == LAST);
endmodule

// File: rtl/srs_fsm.sv
`timescale 1ns/1ps
module srs_fsm
    import srs_pkg::*;
(
    input  logic clk,
    input  logic arst_n,
    input  logic low_s,
    input  logic wdt,
    input  logic hold_done,
    output logic hold_en,
    output logic hold_clr,
    output logic rst_req
);
    seq_state_t state, state_nx;

    // state register
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) state <= ST_SUPPLY_LOW;
        else         state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_SUPPLY_LOW: begin
                if (!low_s) state_nx = ST_HOLD;            // T_GOOD
            end
            ST_HOLD: begin
                if (low_s)          state_nx = ST_SUPPLY_LOW; // T_DIP
                else if (wdt)       state_nx = ST_HOLD;       // T_REHOLD
                else if (hold_done) state_nx = ST_RUN;        // T_EXPIRE
            end
            ST_RUN: begin
                if (low_s)    state_nx = ST_SUPPLY_LOW;    // T_DIP
                else if (wdt) state_nx = ST_HOLD;          // T_WDOG
            end
            default: state_nx = ST_SUPPLY_LOW;
        endcase
    end

    // outputs
    always_comb begin
        hold_en  = (state == ST_HOLD);
        hold_clr = (state != ST_HOLD) || wdt;
        rst_req  = (state_nx != ST_RUN);
    end
endmodule

// File: rtl/srs_drive.sv
`timescale 1ns/1ps
module srs_drive #(
    parameter bit ACTIVE_LOW = 1'b1
) (
    input  logic clk,
    input  logic arst_n,
    input  logic req,
    output logic pin
);
    localparam logic ON_LVL  = ACTIVE_LOW ? 1'b0 : 1'b1;
    localparam logic OFF_LVL = ~ON_LVL;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) pin <= ON_LVL;
        else         pin <= req ? ON_LVL : OFF_LVL;
    end
endmodule

// File: rtl/supply_reset_seq.sv
`timescale 1ns/1ps
module supply_reset_seq #(
    parameter int unsigned HOLD_CYCLES = 10_000_000,
    parameter int unsigned SYNC_STAGES = 2,
    parameter bit          ACTIVE_LOW  = 1'b1
) (
    input  logic clk,
    input  logic pwr_up_n,
    input  logic supply_low,
    input  logic wdt_timeout,
    output logic rst_out
);
    logic low_sync;
    logic hold_en;
    logic hold_clr;
    logic hold_done;
    logic rst_req;

    // the supply is treated as low until proven good
    srs_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk    (clk),
        .arst_n (pwr_up_n),
        .d      (supply_low),
        .q      (low_sync)
    );

    srs_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
        .clk    (clk),
        .arst_n (pwr_up_n),
        .clr    (hold_clr),
        .en     (hold_en),
        .done   (hold_done)
    );

    srs_fsm u_fsm (
        .clk       (clk),
        .arst_n    (pwr_up_n),
        .low_s     (low_sync),
        .wdt       (wdt_timeout),
        .hold_done (hold_done),
        .hold_en   (hold_en),
        .hold_clr  (hold_clr),
        .rst_req   (rst_req)
    );

    srs_drive #(.ACTIVE_LOW(ACTIVE_LOW)) u_drive (
        .clk    (clk),
        .arst_n (pwr_up_n),
        .req    (rst_req),
        .pin    (rst_out)
    );
endmodule

// File: rtl/srs_chk.sv
`timescale 1ns/1ps
module srs_chk #(
    parameter int unsigned HOLD_CYCLES = 10_000_000,
    parameter bit          ACTIVE_LOW  = 1'b1
) (
    input logic clk,
    input logic pwr_up_n,
    input logic rst_out,
    input logic low_s,
    input logic wdt_timeout,
    input logic hold_done
);
    logic asserted;
    assign asserted = ACTIVE_LOW ? !rst_out : rst_out;

    // R2
    supply_low_asserts_chk: assert property (@(posedge clk) disable iff (!pwr_up_n)
        low_s |=> asserted);

    // R3
    release_after_hold_chk: assert property (@(posedge clk) disable iff (!pwr_up_n)
        (!asserted && $past(asserted)) |-> $past(hold_done));

    // R4
    dip_blocks_release_chk: assert property (@(posedge clk) disable iff (!pwr_up_n)
        low_s |=> !hold_done);

    // R5
    wdog_asserts_chk: assert property (@(posedge clk) disable iff (!pwr_up_n)
        wdt_timeout |=> asserted);

    // R6
    wdog_restarts_hold_chk: assert property (@(posedge clk) disable iff (!pwr_up_n)
        (HOLD_CYCLES > 1 && wdt_timeout) |=> !hold_done);
endmodule

bind supply_reset_seq srs_chk #(.HOLD_CYCLES(HOLD_CYCLES), .ACTIVE_LOW(ACTIVE_LOW)) u_chk (
    .clk         (clk),
    .pwr_up_n    (pwr_up_n),
    .rst_out     (rst_out),
    .low_s       (low_sync),
    .wdt_timeout (wdt_timeout),
    .hold_done   (hold_done)
);

// File: tb/sim_supply_reset_seq.sv
`timescale 1ns/1ps
module sim_supply_reset_seq;
    localparam int H = 16;

    logic clk = 1'b0;
    logic pwr_up_n = 1'b0;
    logic supply_low = 1'b0;
    logic wdt_timeout = 1'b0;
    logic rst_n_lo;
    logic rst_hi;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    always #10 clk = ~clk;

    supply_reset_seq #(.HOLD_CYCLES(H), .ACTIVE_LOW(1'b1)) u0 (
        .clk(clk), .pwr_up_n(pwr_up_n), .supply_low(supply_low),
        .wdt_timeout(wdt_timeout), .rst_out(rst_n_lo));

    supply_reset_seq #(.HOLD_CYCLES(H), .ACTIVE_LOW(1'b0)) u1 (
        .clk(clk), .pwr_up_n(pwr_up_n), .supply_low(supply_low),
        .wdt_timeout(wdt_timeout), .rst_out(rst_hi));

    typedef struct packed {
        int dip;     // edges 1..dip sample supply_low high
        int glitch;  // single edge sampling supply_low high (0: none)
        int wdt;     // edge sampling the watchdog pulse (0: none)
        int ast;     // expected edge after which reset is asserted
        int rel;     // expected edge after which reset is released
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1,  0,  0, 3, 1 + H + 3},    // R3 one-cycle dip
        '{40, 0,  0, 3, 40 + H + 3},   // R2 R3 long dip
        '{4,  11, 0, 3, 11 + H + 3},   // R4 glitch early in hold
        '{4,  21, 0, 3, 21 + H + 3},   // R4 glitch at last hold cycle
        '{0,  0,  1, 1, 1 + H},        // R5 watchdog while released
        '{4,  0, 10, 3, 10 + H},       // R6 watchdog inside hold
        '{10, 0,  6, 3, 10 + H + 3},   // R7 watchdog while supply low
        '{10, 0, 13, 3, 10 + H + 3}    // R7 watchdog at last low edge
    };

    function automatic bit act0();
        return !rst_n_lo;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        report();
    end

    // count edges from a falling-edge start until reset releases
    task automatic run_vec(input vec_t v, input string tag);
        int  t_ast = 0;
        int  t_rel = 0;
        bit  pol_bad = 1'b0;
        int  last = (v.dip > v.glitch) ? v.dip : v.glitch;
        if (v.wdt > last) last = v.wdt;
        check(!act0(), "R3 released before vector", int'(act0()), 0);
        for (int k = 1; k <= 300; k++) begin
            @(negedge clk);
            supply_low  = (k <= v.dip) || (k == v.glitch);
            wdt_timeout = (k == v.wdt);
            @(posedge clk);
            #1;
            if (rst_hi != act0()) pol_bad = 1'b1;
            if (act0() && t_ast == 0) t_ast = k;
            if (!act0() && t_ast != 0 && t_rel == 0) t_rel = k;
            if (t_rel != 0 && k >= last) break;
        end
        @(negedge clk);
        supply_low  = 1'b0;
        wdt_timeout = 1'b0;
        check(t_ast == v.ast, {tag, " assert edge"}, t_ast, v.ast);
        check(t_rel == v.rel, {tag, " release edge"}, t_rel, v.rel);
        check(!pol_bad, "R8 polarity pair", int'(pol_bad), 0);
    endtask

    initial begin
        int k_rel;
        // R1 R8: held while power not applied
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(rst_n_lo == 1'b0, "R1 R8 power-up low variant", int'(rst_n_lo), 0);
        check(rst_hi == 1'b1, "R1 R8 power-up high variant", int'(rst_hi), 1);

        // R3: release after power-up
        pwr_up_n = 1'b1;
        k_rel = 0;
        for (int k = 1; k <= 100; k++) begin
            @(posedge clk);
            #1;
            if (!act0()) begin k_rel = k; break; end
        end
        check(k_rel == H + 3, "R3 power-up release edge", k_rel, H + 3);
        check(rst_hi == 1'b0, "R8 released high variant", int'(rst_hi), 0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            repeat (3) @(negedge clk);
            run_vec(VECS[i], $sformatf("R2-R7 vec%0d", i));
        end

        // R1: power loss mid-run asserts without a clock edge
        repeat (4) @(negedge clk);
        #3 pwr_up_n = 1'b0;
        #1;
        check(rst_n_lo == 1'b0, "R1 async assert low variant", int'(rst_n_lo), 0);
        check(rst_hi == 1'b1, "R1 async assert high variant", int'(rst_hi), 1);

        // R7: watchdog during power-up hold-off changes nothing
        @(negedge clk);
        pwr_up_n = 1'b1;
        k_rel = 0;
        for (int k = 1; k <= 100; k++) begin
            wdt_timeout = (k == 2);
            @(posedge clk);
            #1;
            @(negedge clk);
            wdt_timeout = 1'b0;
            if (!act0()) begin k_rel = k; break; end
        end
        check(k_rel == H + 3, "R7 R3 re-power release edge", k_rel, H + 3);
        report();
    end
endmodule